// File: doc/BRIEF.md
# Dual-Phase Lookahead Phase Synthesizer

This block is a digital direct-synthesis core. A single phase register grows by a programmable frequency control word (FCW) on every reference clock edge while the run enable is high. Each enabled step yields two amplitude samples from two matched lookup paths that read one shared, programmable amplitude table. The even sample is looked up at the accumulated phase. The odd sample is looked up at that phase plus half the FCW, so the odd sample sits half a step ahead of the even one.

Sent out alternately, even then odd, the pair forms one stream at twice the reference rate, with a midpoint placed between each pair of regular steps. The table holds pre-distorted amplitude codes that cancel measured converter nonlinearity. Calibration software loads the table through a small write port while the synthesizer is idle. The downstream current-mode multiplexer and the converter take the pair together with its valid flag.

Top module: `dpl_synth_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the phase is zero, `smp_valid` is low, and both sample outputs are zero.
- R2: On each clock edge with `en` high, the phase advances by `fcw` modulo 2^ACC_W. On an edge with `en` low, the phase holds its value.
- R3: The even sample of a pair equals the table entry whose index is the top ADDR_W bits of the phase P held at the enabled edge that started the pair.
- R4: The odd sample of the same pair equals the table entry indexed by the top ADDR_W bits of (P + floor(fcw/2)) modulo 2^ACC_W. The half step is `fcw` shifted right by one, so an odd `fcw` loses its least significant bit.
- R5: A pair started at enabled edge k is presented after edge k+1 with `smp_valid` high. `smp_valid` is high in exactly those cycles, so it equals `en` delayed by two edges.
- R6: On an edge with `tbl_wr` high and `en` low, `tbl_data` is stored at index `tbl_addr`. A table read at that same edge returns the old entry, and reads at later edges return the new one.
- R7: A write request (`tbl_wr` high) on an edge where `en` is high leaves the table unchanged.
- R8: While `smp_valid` is low, `smp_even` and `smp_odd` hold their last values.
- R9: The first pair after reset corresponds to phases 0 and floor(fcw/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; advances the phase and starts a sample pair |
| fcw | input | ACC_W | Frequency control word, the phase increment per clock |
| tbl_wr | input | 1 | Table write request, honoured only while `en` is low |
| tbl_addr | input | ADDR_W | Table entry index to write |
| tbl_data | input | AMP_W | Pre-distorted amplitude code to store |
| smp_even | output | AMP_W | Sample at the accumulated phase |
| smp_odd | output | AMP_W | Sample at the lookahead phase, half a step ahead |
| smp_valid | output | 1 | High when the sample pair is new |

## Verification
The bench builds the block with ACC_W=12, ADDR_W=6 and AMP_W=8. With these values a full 64-entry table loads in 64 cycles, and the phase wraps every 4096/fcw steps. Runs of a few dozen cycles therefore reach modulo wrap on both lookup paths, the half-step truncation for odd words, and the near-full-scale word 4095 that makes the phase step backwards. The small table also brings within reach a write in the cycle just after `en` falls, while a read is still in flight, as well as a rejected write made while running.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

  // Half of a frequency word, truncated: the lookahead offset.
  function automatic logic [63:0] half_step(input logic [63:0] word);
    return word >> 1;
  endfunction

  // Right shift that maps a phase onto a table index.
  function automatic int index_shift(input int acc_w, input int addr_w);
    return acc_w - addr_w;
  endfunction

endpackage

// File: rtl/dpl_phase_acc.sv
module dpl_phase_acc #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [ACC_W-1:0]  fcw,
  output logic [ACC_W-1:0]  phase,
  output logic [ADDR_W-1:0] even_idx,
  output logic [ADDR_W-1:0] lead_idx
);
  localparam int SHIFT = dpl_pkg::index_shift(ACC_W, ADDR_W);

  function automatic logic [ACC_W-1:0] advance(input logic [ACC_W-1:0] p,
                                               input logic [ACC_W-1:0] d);
    return p + d;
  endfunction

  function automatic logic [ADDR_W-1:0] to_index(input logic [ACC_W-1:0] p);
    return ADDR_W'(p >> SHIFT);
  endfunction

  logic [ACC_W-1:0] half_fcw;

  assign half_fcw = ACC_W'(dpl_pkg::half_step(64'(fcw)));
  assign even_idx = to_index(phase);
  assign lead_idx = to_index(advance(phase, half_fcw));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (step_en) begin
      phase <= advance(phase, fcw);
    end
  end
endmodule

// File: rtl/dpl_addr_stage.sv
module dpl_addr_stage #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_even,
  input  logic [ADDR_W-1:0] in_odd,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_even,
  output logic [ADDR_W-1:0] out_odd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_even  <= '0;
      out_odd   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_even <= in_even;
        out_odd  <= in_odd;
      end
    end
  end
endmodule

// File: rtl/dpl_amp_table.sv
module dpl_amp_table #(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [AMP_W-1:0]  wr_code,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_idx_a,
  input  logic [ADDR_W-1:0] rd_idx_b,
  output logic [AMP_W-1:0]  rd_code_a,
  output logic [AMP_W-1:0]  rd_code_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [AMP_W-1:0] codes [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      codes[wr_idx] <= wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_code_a <= '0;
      rd_code_b <= '0;
    end else if (rd_en) begin
      rd_code_a <= codes[rd_idx_a];
      rd_code_b <= codes[rd_idx_b];
    end
  end
endmodule

// File: rtl/dpl_synth_top.sv
module dpl_synth_top #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ACC_W-1:0]  fcw,
  input  logic              tbl_wr,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [AMP_W-1:0]  tbl_data,
  output logic [AMP_W-1:0]  smp_even,
  output logic [AMP_W-1:0]  smp_odd,
  output logic              smp_valid
);
  logic [ACC_W-1:0]  acc_phase;
  logic [ADDR_W-1:0] even_idx;
  logic [ADDR_W-1:0] lead_idx;
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_even_idx;
  logic [ADDR_W-1:0] s1_odd_idx;
  logic              wr_accept;

  // Calibration writes only land while the synthesizer is idle.
  assign wr_accept = tbl_wr & ~en;

  dpl_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (en),
    .fcw      (fcw),
    .phase    (acc_phase),
    .even_idx (even_idx),
    .lead_idx (lead_idx)
  );

  dpl_addr_stage #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (en),
    .in_even   (even_idx),
    .in_odd    (lead_idx),
    .out_valid (s1_valid),
    .out_even  (s1_even_idx),
    .out_odd   (s1_odd_idx)
  );

  dpl_amp_table #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_accept),
    .wr_idx    (tbl_addr),
    .wr_code   (tbl_data),
    .rd_en     (s1_valid),
    .rd_idx_a  (s1_even_idx),
    .rd_idx_b  (s1_odd_idx),
    .rd_code_a (smp_even),
    .rd_code_b (smp_odd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
    end else begin
      smp_valid <= s1_valid;
    end
  end
endmodule

// File: rtl/dpl_synth_chk.sv
module dpl_synth_chk #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [ACC_W-1:0]  fcw,
  input logic [ACC_W-1:0]  acc_phase,
  input logic              s1_valid,
  input logic [ADDR_W-1:0] s1_odd_idx,
  input logic [AMP_W-1:0]  smp_even,
  input logic [AMP_W-1:0]  smp_odd,
  input logic              smp_valid
);
  logic [ACC_W-1:0] prev_phase;
  logic [ACC_W-1:0] prev_fcw;
  logic             prev_en;
  logic [ACC_W-1:0] exp_lead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_phase <= '0;
      prev_fcw   <= '0;
      prev_en    <= 1'b0;
    end else begin
      prev_phase <= acc_phase;
      prev_fcw   <= fcw;
      prev_en    <= en;
    end
  end

  assign exp_lead = prev_phase + (prev_fcw >> 1);

  // R2: an enabled edge adds the word, modulo the phase width
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    prev_en |-> acc_phase == prev_phase + prev_fcw);

  // R2: a disabled edge leaves the phase alone
  a_r2_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !prev_en |-> acc_phase == prev_phase);

  // R4: the lookahead index is half a word ahead of the captured phase
  a_r4_lead_index: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |-> s1_odd_idx == ADDR_W'(exp_lead >> (ACC_W - ADDR_W)));

  // R5: an enabled edge is followed by a valid pair one edge later
  a_r5_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> smp_valid);

  // R5: no pair without an enabled edge
  a_r5_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !smp_valid);

  // R8: outputs hold while nothing new is presented
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ($stable(smp_even) && $stable(smp_odd)));
endmodule

bind dpl_synth_top dpl_synth_chk #(
  .ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .fcw        (fcw),
  .acc_phase  (acc_phase),
  .s1_valid   (s1_valid),
  .s1_odd_idx (s1_odd_idx),
  .smp_even   (smp_even),
  .smp_odd    (smp_odd),
  .smp_valid  (smp_valid)
);

// File: tb/dpl_synth_top_tb.sv
module dpl_synth_top_tb;
  localparam int ACC_W  = 12;
  localparam int ADDR_W = 6;
  localparam int AMP_W  = 8;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int MASK   = (1 << ACC_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [ACC_W-1:0]  fcw = '0;
  logic              tbl_wr = 1'b0;
  logic [ADDR_W-1:0] tbl_addr = '0;
  logic [AMP_W-1:0]  tbl_data = '0;
  logic [AMP_W-1:0]  smp_even;
  logic [AMP_W-1:0]  smp_odd;
  logic              smp_valid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Behavioural reference state
  int tbl [DEPTH];
  int m_acc, m_v1, m_ie1, m_io1, m_v2, m_e2, m_o2;

  always #4 clk = ~clk;

  dpl_synth_top #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .fcw(fcw), .tbl_wr(tbl_wr),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .smp_even(smp_even),
    .smp_odd(smp_odd), .smp_valid(smp_valid)
  );

  function automatic int idx_of(input int p);
    return (p & MASK) / (1 << (ACC_W - ADDR_W));
  endfunction

  task automatic check_val(input string tag, input string what,
                           input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check_val("R5", "smp_valid", int'(smp_valid), m_v2);
    if (m_v2 != 0) begin
      check_val({tag, " R3"}, "smp_even", int'(smp_even), m_e2);
      check_val({tag, " R4"}, "smp_odd", int'(smp_odd), m_o2);
    end else begin
      check_val("R8 hold", "smp_even", int'(smp_even), m_e2);
      check_val("R8 hold", "smp_odd", int'(smp_odd), m_o2);
    end
  endtask

  task automatic step(input bit e, input int f, input bit w, input int wa,
                      input int wd, input string tag);
    en = e; fcw = ACC_W'(f); tbl_wr = w;
    tbl_addr = ADDR_W'(wa); tbl_data = AMP_W'(wd);
    @(posedge clk);
    if (m_v1 != 0) begin
      m_e2 = tbl[m_ie1];
      m_o2 = tbl[m_io1];
    end
    m_v2 = m_v1;
    m_v1 = e;
    if (e) begin
      m_ie1 = idx_of(m_acc);
      m_io1 = idx_of(m_acc + (f / 2));
      m_acc = (m_acc + f) & MASK;
    end
    if (w && !e) tbl[wa] = wd;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset();
    en = 0; tbl_wr = 0;
    rst_n = 0;
    m_acc = 0; m_v1 = 0; m_v2 = 0; m_e2 = 0; m_o2 = 0; m_ie1 = 0; m_io1 = 0;
    repeat (2) @(negedge clk);
    check_val("R1", "smp_valid in reset", int'(smp_valid), 0);
    check_val("R1", "smp_even in reset", int'(smp_even), 0);
    check_val("R1", "smp_odd in reset", int'(smp_odd), 0);
    rst_n = 1;
    @(negedge clk);
    check_val("R1", "smp_valid after release", int'(smp_valid), 0);
    check_val("R1", "smp_even after release", int'(smp_even), 0);
  endtask

  initial begin
    do_reset();
    // Calibration load while idle
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 1, i, (i * 37 + 5) & 8'hFF, "R6 load");
    // First enabled edge with a write request that must be rejected
    step(1, 128, 1, 0, 8'hAA, "R7");
    check_val("R5", "valid one edge after enable", int'(smp_valid), 0);
    step(1, 128, 0, 0, 0, "R9");
    check_val("R9", "first even at phase 0", int'(smp_even), (0 * 37 + 5) & 8'hFF);
    check_val("R9", "first odd at phase fcw/2", int'(smp_odd), (1 * 37 + 5) & 8'hFF);
    for (int i = 0; i < 40; i++) step(1, 128, 0, 0, 0, "R2 wrap");
    for (int i = 0; i < 30; i++) step(1, 201, 0, 0, 0, "R4 odd word");
    for (int i = 0; i < 20; i++) step(1, 4095, 0, 0, 0, "R2 near full scale");
    for (int i = 0; i < 24; i++) step(i % 3 != 0, 77, 0, 0, 0, "R2 gated");
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, 0, "R2 zero word");
    // Writes right after enable falls, while reads are still in flight
    step(1, 64, 0, 0, 0, "R6 pre");
    for (int i = 0; i < 8; i++)
      step(0, 64, 1, (m_acc / 64 + i) % DEPTH, 200 + i, "R6 write");
    step(1, 64, 1, 3, 1, "R7 running");
    for (int i = 0; i < 80; i++) step(1, 64, 0, 0, 0, "R6 readback");
    // Reset mid run
    do_reset();
    step(1, 100, 0, 0, 0, "R9 after reset");
    step(1, 100, 0, 0, 0, "R9 after reset");
    check_val("R9", "even at phase 0", int'(smp_even), tbl[0]);
    check_val("R9", "odd at phase 50", int'(smp_odd), tbl[idx_of(50)]);
    for (int i = 0; i < 12; i++) step(1, 100, 0, 0, 0, "R2 after reset");
    step(0, 0, 0, 0, 0, "R8 drain");
    step(0, 0, 0, 0, 0, "R8 drain");
    step(0, 0, 0, 0, 0, "R8 idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule